// File: doc/BRIEF.md
# Serial Peripheral Port with Sticky Status Flags

This block connects a processor bus to a four-wire serial link. It can run as the clock-driving host or as a clocked device. The serial engine uses one timing only: the clock idles low, bits are sampled on the rising edge and changed on the falling edge, and the most significant bit goes first. When the block is the host, a fixed divider sets the serial clock, with a high and a low phase of `HALF_CYC` system cycles each. When the block is a device, it samples the external clock, data and select lines through a two-stage synchronizer.

Software sees three byte-wide registers on a two-bit address. Address 0 is the data register, address 1 is the control register and address 2 is the status/select register. The status register holds four sticky flags: transfer done, write collision, overrun and host-mode fault. Each flag is set by hardware and cleared only by a set order of bus accesses. The same register also holds three software bits. One turns off the serial data output, one makes the select level come from a register bit instead of the pin, and one gives that level.

A single interrupt line combines the flags when interrupts are enabled. A host-mode fault takes the block off the bus by clearing its enable and host bits.

Top module: `spi_flag_port`

## Requirements
- R1: After reset, the control register (address 1) and the status register (address 2) read 0x00, irq is low, and sclk_oe, mosi_oe and miso_oe are low.
- R2: In host mode (control bit 1 = 1, enable bit 0 = 1), a write to the data register (address 0) starts an 8-bit exchange. sclk_out starts low and MSB is on mosi_out before the first rising edge. At the end the received byte can be read at address 0 and status bit 7 (done) is set.
- R3: Done clears only when a status read made while done is set is followed by a data register read or write. A data write while done is set and no such status read has been made is ignored and starts no exchange.
- R4: A data write while an exchange is in progress sets status bit 6 (collision) and leaves the byte being shifted unchanged. Collision clears only when a status read is followed by a data register access; a status read alone leaves it set.
- R5: If an exchange completes while done is still set, status bit 5 (overrun) is set and the byte already in the data register is kept. A status read clears overrun.
- R6: When enable and host are set and the internal select is active (low), status bit 4 (fault) is set and control bits 0 and 1 are cleared. Fault clears only when a status read made while fault is set is followed by a control register write.
- R7: Status bit 2 = 1 turns off the serial output enable: mosi_oe in host mode, miso_oe in device mode.
- R8: With status bit 1 = 1, the internal select follows status bit 0 (0 = selected, 1 = not selected) and the ss_n_in pin is ignored. With bit 1 = 0, the pin sets it.
- R9: Status bit 3 always reads 0, and writes to address 2 do not change bits 7 to 4.
- R10: irq is high exactly when control bit 2 (interrupt enable) is 1 and at least one of done, overrun or fault is set.
- R11: In device mode (enable = 1, host = 0, selected), a byte written while not selected is shifted out MSB first on miso_out. The byte clocked in on mosi_in lands in the data register and sets done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sclk_in | input | 1 | Serial clock from an external host |
| sclk_out | output | 1 | Serial clock driven in host mode |
| sclk_oe | output | 1 | Enable for sclk_out |
| mosi_in | input | 1 | Serial data in, device mode |
| mosi_out | output | 1 | Serial data out, host mode |
| mosi_oe | output | 1 | Enable for mosi_out |
| miso_in | input | 1 | Serial data in, host mode |
| miso_out | output | 1 | Serial data out, device mode |
| miso_oe | output | 1 | Enable for miso_out |
| ss_n_in | input | 1 | Select pin, active low |

## Verification
In host mode the serial data output is looped back inverted to the serial input. Each received byte must then be the complement of the byte sent, which shows the bit order and the sampling edge are right. Seeded random bytes are mixed with the all-zeros and all-ones bytes to catch stuck or dropped bit positions. When the output is turned off, the loopback floats to all ones, which is how the bench tells a turned-off output from a driven one.

In device mode the bench drives a slow external clock and two different bytes. The first byte checks both shift directions. The second, sent without reading the first, checks overrun and that the held byte is kept. The clear orders are exercised by changing which access comes between a status read and the next data or control access.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // control register, bit 2 down to bit 0
  typedef struct packed {
    logic irq_en;
    logic host;
    logic run_en;
  } ctrl_t;

  // software bits in the status register, bit 2 down to bit 0
  typedef struct packed {
    logic out_off;
    logic sel_soft;
    logic sel_level;
  } selcfg_t;

  typedef struct packed {
    logic done;
    logic wcol;
    logic ovr;
    logic fault;
  } flags_t;

  function automatic logic [7:0] pack_status(flags_t f, selcfg_t s);
    return {f.done, f.wcol, f.ovr, f.fault, 1'b0, s.out_off, s.sel_soft, s.sel_level};
  endfunction

  function automatic logic [7:0] pack_ctrl(ctrl_t c);
    return {5'd0, c};
  endfunction

  // 1 when the internal select is active
  function automatic logic sel_active(selcfg_t s, logic pin_n);
    return s.sel_soft ? !s.sel_level : !pin_n;
  endfunction

  function automatic logic want_irq(ctrl_t c, flags_t f);
    return c.irq_en & (f.done | f.ovr | f.fault);
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic sample_ev,
  output logic shift_ev
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          phase_end;

  assign phase_end = run && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (phase_end) begin
      cnt_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign sclk      = sclk_q;
  assign sample_ev = phase_end && !sclk_q;
  assign shift_ev  = phase_end && sclk_q;

  // clock returns low whenever the engine is idle
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              host,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sample_ev,
  input  logic              shift_ev,
  input  logic              in_bit,
  input  logic              abort,
  output logic              out_bit,
  output logic              active,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int BW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic              cap_q;
  logic [BW-1:0]     bits_q;
  logic              active_q;
  logic              done_q;
  logic              last_shift;

  assign last_shift = shift_ev && (bits_q == BW'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cap_q    <= 1'b0;
      bits_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!enable) begin
        active_q <= 1'b0;
        bits_q   <= '0;
      end else if (load) begin
        sh_q     <= load_data;
        bits_q   <= '0;
        active_q <= host;
      end else if (abort) begin
        bits_q <= '0;
      end else begin
        if (sample_ev) cap_q <= in_bit;
        if (shift_ev) begin
          sh_q <= {sh_q[DATA_W-2:0], cap_q};
          if (last_shift) begin
            bits_q   <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bits_q <= bits_q + BW'(1);
          end
        end
      end
    end
  end

  assign out_bit   = sh_q[DATA_W-1];
  assign active    = active_q;
  assign xfer_done = done_q;
  assign rx_data   = sh_q;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              busy,
  input  logic              sel_low,
  output ctrl_t             ctrl,
  output selcfg_t           selcfg,
  output logic              irq,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data
);
  ctrl_t             ctrl_q;
  selcfg_t           selcfg_q;
  flags_t            flags_q;
  logic [DATA_W-1:0] rx_q;
  logic              arm_done, arm_wcol, arm_fault;

  reg_sel_e which;
  logic rd_data, wr_data, rd_stat, wr_stat, wr_ctrl;
  logic data_touch, wcol_hit, blocked, fault_cond;

  assign which      = reg_sel_e'(bus_addr);
  assign rd_data    = bus_sel && !bus_wr && (which == REG_DATA);
  assign wr_data    = bus_sel &&  bus_wr && (which == REG_DATA);
  assign rd_stat    = bus_sel && !bus_wr && (which == REG_STAT);
  assign wr_stat    = bus_sel &&  bus_wr && (which == REG_STAT);
  assign wr_ctrl    = bus_sel &&  bus_wr && (which == REG_CTRL);
  assign data_touch = rd_data || wr_data;
  assign wcol_hit   = wr_data && busy;
  assign blocked    = flags_q.done && !arm_done;
  assign fault_cond = ctrl_q.run_en && ctrl_q.host && sel_low;

  assign tx_load = wr_data && !busy && !blocked && ctrl_q.run_en;
  assign tx_data = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      selcfg_q  <= '0;
      flags_q   <= '0;
      rx_q      <= '0;
      arm_done  <= 1'b0;
      arm_wcol  <= 1'b0;
      arm_fault <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[2:0]);
      if (fault_cond) begin
        ctrl_q.run_en <= 1'b0;
        ctrl_q.host   <= 1'b0;
      end
      if (wr_stat) selcfg_q <= selcfg_t'(bus_wdata[2:0]);

      // done flag and received byte
      if (data_touch && arm_done) flags_q.done <= 1'b0;
      if (xfer_done && !flags_q.done) begin
        flags_q.done <= 1'b1;
        rx_q         <= rx_data;
      end

      // overrun: the held byte stays, the new one is dropped
      if (rd_stat) flags_q.ovr <= 1'b0;
      if (xfer_done && flags_q.done) flags_q.ovr <= 1'b1;

      if (data_touch && arm_wcol) flags_q.wcol <= 1'b0;
      if (wcol_hit) flags_q.wcol <= 1'b1;

      if (wr_ctrl && arm_fault) flags_q.fault <= 1'b0;
      if (fault_cond) flags_q.fault <= 1'b1;

      // a status read arms the clear of whichever flags it saw set
      if (rd_stat) begin
        arm_done  <= flags_q.done;
        arm_wcol  <= flags_q.wcol;
        arm_fault <= flags_q.fault;
      end else begin
        if (data_touch) begin
          arm_done <= 1'b0;
          arm_wcol <= 1'b0;
        end
        if (wr_ctrl) arm_fault <= 1'b0;
      end
    end
  end

  always_comb begin
    case (which)
      REG_DATA: bus_rdata = rx_q;
      REG_CTRL: bus_rdata = DATA_W'(pack_ctrl(ctrl_q));
      REG_STAT: bus_rdata = DATA_W'(pack_status(flags_q, selcfg_q));
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign selcfg = selcfg_q;
  assign irq    = want_irq(ctrl_q, flags_q);

  assert_wcol_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> flags_q.wcol);

  assert_ovr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && flags_q.done) |=> (flags_q.ovr && $stable(rx_q)));

  assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && flags_q.done && !arm_done) |=> flags_q.done);

  assert_fault_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cond |=> (flags_q.fault && !ctrl_q.run_en && !ctrl_q.host));

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.fault && !(wr_ctrl && arm_fault)) |=> flags_q.fault);
endmodule

// File: rtl/spi_flag_port.sv
module spi_flag_port
  import spi_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_n_in
);
  ctrl_t             ctrl;
  selcfg_t           selcfg;
  logic              ss_n_s, sclk_s, mosi_s, sclk_prev_q;
  logic              sel_low, slave_sel, s_rise, s_fall;
  logic              m_sclk, m_sample, m_shift;
  logic              core_active, core_done, out_bit, busy, tx_load;
  logic [DATA_W-1:0] rx_data, tx_data;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_in, sclk_in, mosi_in}),
    .q({ss_n_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign sel_low   = sel_active(selcfg, ss_n_s);
  assign slave_sel = ctrl.run_en && !ctrl.host && sel_low;
  assign s_rise    = slave_sel &&  sclk_s && !sclk_prev_q;
  assign s_fall    = slave_sel && !sclk_s &&  sclk_prev_q;
  assign busy      = core_active || slave_sel;

  spi_sclk_gen #(.HALF_CYC(HALF_CYC)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(core_active),
    .sclk(m_sclk), .sample_ev(m_sample), .shift_ev(m_shift)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .enable(ctrl.run_en), .host(ctrl.host),
    .load(tx_load), .load_data(tx_data),
    .sample_ev(ctrl.host ? m_sample : s_rise),
    .shift_ev(ctrl.host ? m_shift : s_fall),
    .in_bit(ctrl.host ? miso_in : mosi_s),
    .abort(!ctrl.host && !sel_low),
    .out_bit(out_bit), .active(core_active),
    .xfer_done(core_done), .rx_data(rx_data)
  );

  spi_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(core_done), .rx_data(rx_data),
    .busy(busy), .sel_low(sel_low),
    .ctrl(ctrl), .selcfg(selcfg), .irq(irq),
    .tx_load(tx_load), .tx_data(tx_data)
  );

  assign sclk_out = m_sclk;
  assign sclk_oe  = ctrl.run_en && ctrl.host;
  assign mosi_out = out_bit;
  assign mosi_oe  = ctrl.run_en && ctrl.host && !selcfg.out_off;
  assign miso_out = out_bit;
  assign miso_oe  = slave_sel && !selcfg.out_off;
endmodule

// File: tb/spi_flag_port_tb.sv
module spi_flag_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, sclk_out, sclk_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic       sclk_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
  logic       bench_slave = 1'b0;
  logic       miso_in;
  int         n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  // host-mode loopback: inverted data back, pulled high when output is off
  assign miso_in = bench_slave ? 1'b0 : (mosi_oe ? ~mosi_out : 1'b1);

  spi_flag_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .ss_n_in(ss_n_in)
  );

  function automatic logic [7:0] exp_stat(logic d, logic w, logic o, logic f, logic [2:0] cfg);
    return {d, w, o, f, 1'b0, cfg};
  endfunction

  function automatic logic [7:0] exp_loop(logic [7:0] tx, logic driven);
    return driven ? ~tx : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr_t(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_rd_t(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(req, {7'd0, irq}, 8'd1);
  endtask

  task automatic slave_xfer(input logic [7:0] m, output logic [7:0] got);
    ss_n_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 miso_oe while selected", {7'd0, miso_oe}, 8'd1);
    for (int i = 7; i >= 0; i--) begin
      mosi_in = m[i];
      repeat (8) @(negedge clk);
      sclk_in = 1'b1;
      got[i] = miso_out;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd, tx, got;
    logic [7:0] pats[8];
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd_t(2'd2, rd); chk("R1 status", rd, 8'h00);
    bus_rd_t(2'd1, rd); chk("R1 ctrl", rd, 8'h00);
    chk("R1 irq/oe", {4'd0, irq, sclk_oe, mosi_oe, miso_oe}, 8'h00);

    // R2 + R10: host transfer with interrupts off
    bus_wr_t(2'd1, 8'h03);
    bus_wr_t(2'd0, 8'hA5);
    chk("R2 idle sclk and first bit", {6'd0, sclk_out, mosi_out}, 8'h01);
    repeat (120) @(negedge clk);
    chk("R10 irq off when disabled", {7'd0, irq}, 8'd0);
    bus_rd_t(2'd2, rd); chk("R2 done set", rd, exp_stat(1, 0, 0, 0, 3'd0));
    bus_rd_t(2'd0, rd); chk("R2 rx byte", rd, exp_loop(8'hA5, 1));
    bus_rd_t(2'd2, rd); chk("R3 done cleared", rd, 8'h00);

    // R2 random and directed bytes with interrupts on
    bus_wr_t(2'd1, 8'h07);
    pats[0] = 8'h00; pats[1] = 8'hFF;
    for (int i = 2; i < 8; i++) pats[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) begin
      tx = pats[i];
      bus_wr_t(2'd0, tx);
      wait_irq("R10 irq on done");
      bus_rd_t(2'd2, rd); chk("R2 done flag", rd, exp_stat(1, 0, 0, 0, 3'd0));
      bus_rd_t(2'd0, rd); chk("R2 loop byte", rd, exp_loop(tx, 1));
      chk("R10 irq drops", {7'd0, irq}, 8'd0);
    end

    // R3 blocked write while done is set and unarmed
    bus_wr_t(2'd0, 8'h5A);
    wait_irq("R3 setup");
    bus_wr_t(2'd0, 8'h3C);
    begin
      logic saw = 1'b0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (sclk_out) saw = 1'b1;
      end
      chk("R3 blocked write starts nothing", {7'd0, saw}, 8'd0);
    end
    bus_rd_t(2'd2, rd); chk("R3 done held", rd, exp_stat(1, 0, 0, 0, 3'd0));
    bus_rd_t(2'd0, rd); chk("R3 old byte kept", rd, exp_loop(8'h5A, 1));

    // R4 collision
    bus_wr_t(2'd0, 8'h96);
    repeat (10) @(negedge clk);
    bus_wr_t(2'd0, 8'h11);
    wait_irq("R4 setup");
    bus_rd_t(2'd2, rd); chk("R4 collision set", rd, exp_stat(1, 1, 0, 0, 3'd0));
    bus_rd_t(2'd2, rd); chk("R4 status read alone keeps it", rd, exp_stat(1, 1, 0, 0, 3'd0));
    bus_rd_t(2'd0, rd); chk("R4 shifted byte intact", rd, exp_loop(8'h96, 1));
    bus_rd_t(2'd2, rd); chk("R4 collision cleared", rd, 8'h00);

    // R7 output off in host mode
    bus_wr_t(2'd2, 8'h04);
    chk("R7 mosi_oe off", {6'd0, sclk_oe, mosi_oe}, 8'h02);
    bus_wr_t(2'd0, 8'h3C);
    wait_irq("R7 setup");
    bus_rd_t(2'd2, rd); chk("R7 status", rd, exp_stat(1, 0, 0, 0, 3'd4));
    bus_rd_t(2'd0, rd); chk("R7 undriven line", rd, exp_loop(8'h3C, 0));

    // R9 flags and bit 3 not writable
    bus_wr_t(2'd2, 8'hF0);
    bus_rd_t(2'd2, rd); chk("R9 upper bits", rd, 8'h00);
    bus_wr_t(2'd2, 8'hFF);
    bus_rd_t(2'd2, rd); chk("R9 bit3 zero", rd, 8'h07);
    bus_wr_t(2'd2, 8'h00);

    // R6 fault through software select
    bus_wr_t(2'd1, 8'h04);
    bus_wr_t(2'd2, 8'h02);
    bus_wr_t(2'd1, 8'h07);
    repeat (3) @(negedge clk);
    bus_rd_t(2'd1, rd); chk("R6 enable and host cleared", rd, 8'h04);
    chk("R6 outputs off, R10 irq", {6'd0, sclk_oe, irq}, 8'h01);
    bus_wr_t(2'd1, 8'h04);
    chk("R6 ctrl write without status read", {7'd0, irq}, 8'd1);
    bus_wr_t(2'd2, 8'h03);
    bus_rd_t(2'd2, rd); chk("R6 fault flag", rd, exp_stat(0, 0, 0, 1, 3'd3));
    bus_wr_t(2'd1, 8'h04);
    chk("R6 fault cleared irq", {7'd0, irq}, 8'd0);
    bus_rd_t(2'd2, rd); chk("R6 fault cleared", rd, 8'h03);

    // R6/R8 fault through the pin
    bus_wr_t(2'd2, 8'h00);
    ss_n_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr_t(2'd1, 8'h03);
    repeat (3) @(negedge clk);
    bus_rd_t(2'd1, rd); chk("R8 pin select faults host", rd, 8'h00);
    ss_n_in = 1'b1;
    bus_rd_t(2'd2, rd); chk("R6 pin fault flag", rd, 8'h10);
    bus_wr_t(2'd1, 8'h00);
    bus_rd_t(2'd2, rd); chk("R6 pin fault cleared", rd, 8'h00);

    // R11 + R5 device mode
    bench_slave = 1'b1;
    bus_wr_t(2'd1, 8'h05);
    bus_wr_t(2'd0, 8'hB4);
    slave_xfer(8'h3E, got);
    chk("R11 miso byte", got, 8'hB4);
    chk("R11 irq, oe off when deselected", {6'd0, irq, miso_oe}, 8'h02);
    slave_xfer(8'hC1, got);
    bus_rd_t(2'd2, rd); chk("R5 overrun", rd, exp_stat(1, 0, 1, 0, 3'd0));
    bus_rd_t(2'd0, rd); chk("R5 first byte kept", rd, 8'h3E);
    bus_rd_t(2'd2, rd); chk("R5 overrun cleared", rd, 8'h00);

    // R8 software select, R7 in device mode
    bus_wr_t(2'd2, 8'h03);
    ss_n_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 soft deselect ignores pin", {7'd0, miso_oe}, 8'd0);
    bus_wr_t(2'd2, 8'h02);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 soft select", {7'd0, miso_oe}, 8'd1);
    bus_wr_t(2'd2, 8'h06);
    chk("R7 miso_oe off", {7'd0, miso_oe}, 8'd0);
    bus_wr_t(2'd2, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule